// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Modulator

This block turns a signed current-demand word into the two gate-level drive bits of one H-bridge. An internal up/down counter forms a triangle reference, and a mirror of that triangle (its 180-degree copy) is derived from it. Leg A is driven high while the demand level lies above the rising/falling triangle. Leg B is driven high while the mirrored triangle lies above the demand level. A demand of zero puts both legs in phase at half duty, so the bridge applies no net voltage. A positive demand widens leg A and narrows leg B by the same number of cycles, which pushes current from A to B. A negative demand does the opposite. The load sees two switching edges per triangle period.

The triangle half-span `P` is a programmable period setting. The demand is an offset from the midpoint `floor(P/2)`, and it saturates at full or zero duty. Both the demand and `P` are captured only at the start of each triangle period, so a pulse is never cut short partway through. A period-start strobe marks each capture. Dropping `enable` forces both legs low and restarts the triangle.

Top module: `bridge_pwm_mod`

## Requirements
- R1: With `P = max(period, 2)`, the triangle counter visits 0,1,…,P-1 then P-1,…,0, so one period lasts 2·P cycles. `valley_stb` is high for exactly the one output cycle that begins each period.
- R2: Let `L = clamp(floor(P/2) + demand, 0, P)`. Over one period, `drv_a` is high for exactly 2·L cycles. Per cycle, `drv_a = (L > count)`.
- R3: Over one period, `drv_b` is high for exactly 2·(P-L) cycles. Per cycle, `drv_b = ((P - count) > L)`.
- R4: With zero demand and an even `P`, `drv_a` and `drv_b` are equal on every cycle, each at 50% duty. This gives zero differential drive.
- R5: A demand of `P - floor(P/2)` or more holds `drv_a` high and `drv_b` low for the whole period. A demand of `-floor(P/2)` or less does the reverse.
- R6: `demand` and `period` are sampled only in the first cycle of a period. Changes at any other time have no effect until the next period.
- R7: While `enable` is low at a clock edge, both drive bits and the strobe are low after that edge. The first enabled cycle that follows starts a fresh period from count 0.
- R8: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge enable; low forces both legs off |
| demand | input | CW+1 | Signed offset of the demand level from the triangle midpoint |
| period | input | CW | Triangle half-span P in cycles (values below 2 act as 2) |
| drv_a | output | 1 | Leg A drive, registered |
| drv_b | output | 1 | Leg B drive, registered |
| valley_stb | output | 1 | High in the first output cycle of each period |

## Verification
A zero demand at an even span tells the in-phase, equal-duty balance point (R4) apart from an off-by-one in either comparison. Positive and negative demands beyond the span each check that saturation lands exactly on full and zero duty. Random spans and demands, including odd spans and spans below 2, are checked cycle by cycle against a bench model and per period by counted duty. Demand changes in the middle of a period, and short disable pulses, show whether sampling is limited to the period start and whether the restart is clean.

// File: rtl/bridge_pwm_mod.sv
`timescale 1ns/1ps
module bridge_pwm_mod #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic signed [CW:0]   demand,
  input  logic [CW-1:0]        period,
  output logic                 drv_a,
  output logic                 drv_b,
  output logic                 valley_stb
);
  localparam int LW = CW + 2;

  logic [CW-1:0] cnt, per_q, lvl_q;
  logic          up;

  wire at_start = (cnt == '0) && up;

  wire [CW-1:0] per_in = (period < CW'(2)) ? CW'(2) : period;
  wire [CW-1:0] per_e  = at_start ? per_in : per_q;

  wire signed [LW-1:0] sum  = $signed({2'b00, per_in >> 1}) + $signed({demand[CW], demand});
  wire signed [LW-1:0] span = $signed({2'b00, per_in});

  wire [CW-1:0] lvl_new = (sum < 0)    ? '0 :
                          (sum > span) ? per_in : sum[CW-1:0];
  wire [CW-1:0] lvl_e   = at_start ? lvl_new : lvl_q;
  wire [CW-1:0] tri180  = per_e - cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      up         <= 1'b1;
      per_q      <= '0;
      lvl_q      <= '0;
      drv_a      <= 1'b0;
      drv_b      <= 1'b0;
      valley_stb <= 1'b0;
    end else if (!enable) begin
      cnt        <= '0;
      up         <= 1'b1;
      drv_a      <= 1'b0;
      drv_b      <= 1'b0;
      valley_stb <= 1'b0;
    end else begin
      per_q      <= per_e;
      lvl_q      <= lvl_e;
      drv_a      <= lvl_e > cnt;
      drv_b      <= tri180 > lvl_e;
      valley_stb <= at_start;
      if (up) begin
        if (cnt == per_e - CW'(1)) up <= 1'b0;
        else                       cnt <= cnt + CW'(1);
      end else begin
        if (cnt == '0) up <= 1'b1;
        else           cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/bridge_pwm_mod_chk.sv
`timescale 1ns/1ps
module bridge_pwm_mod_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          drv_a,
  input logic          drv_b,
  input logic          valley_stb,
  input logic [CW-1:0] cnt,
  input logic          up,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] lvl_q
);
  p_count_in_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable)) |-> (cnt < per_q));

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valley_stb |=> !valley_stb);

  p_level_saturated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable)) |-> (lvl_q <= per_q));

  p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(cnt == '0 && up)) |=> ($stable(lvl_q) && $stable(per_q)));

  p_disable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!drv_a && !drv_b && !valley_stb));
endmodule

bind bridge_pwm_mod bridge_pwm_mod_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .drv_a(drv_a), .drv_b(drv_b),
  .valley_stb(valley_stb), .cnt(cnt), .up(up), .per_q(per_q), .lvl_q(lvl_q)
);

// File: tb/bridge_pwm_mod_tb_top.sv
`timescale 1ns/1ps
module bridge_pwm_mod_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n = 1'b0;
  logic                enable = 1'b0;
  logic signed [CW:0]  demand = '0;
  logic [CW-1:0]       period = CW'(16);
  logic                drv_a, drv_b, valley_stb;

  bridge_pwm_mod #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .demand(demand),
    .period(period), .drv_a(drv_a), .drv_b(drv_b), .valley_stb(valley_stb)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int p, input int d);
    int v = p / 2 + d;
    if (v < 0) v = 0;
    if (v > p) v = p;
    return v;
  endfunction

  // reference model, evaluated from the requirements at each edge
  int m_cnt = 0, m_P = 2, m_L = 1;
  bit m_up = 1'b1, eA = 1'b0, eB = 1'b0, eS = 1'b0;
  always @(posedge clk) begin
    bit st;
    if (!rst_n || !enable) begin
      eA = 0; eB = 0; eS = 0; m_cnt = 0; m_up = 1;
    end else begin
      st = (m_cnt == 0) && m_up;
      if (st) begin
        m_P = (int'(period) < 2) ? 2 : int'(period);
        m_L = lvl_of(m_P, int'(demand));
      end
      eA = m_L > m_cnt;
      eB = (m_P - m_cnt) > m_L;
      eS = st;
      if (m_up) begin
        if (m_cnt == m_P - 1) m_up = 0; else m_cnt++;
      end else begin
        if (m_cnt == 0) m_up = 1; else m_cnt--;
      end
    end
  end

  // per-cycle and per-period checks, sampled 1 ns after the edge
  bit per_ok = 0, r4_mode = 0;
  int cA = 0, cB = 0, cyc = 0, pL = 0, pP = 0, lastA = -1, lastB = -1;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (!enable) begin
        chk(!drv_a && !drv_b && !valley_stb, "R7 outputs off while disabled",
            {drv_a, drv_b, valley_stb}, 0);
        per_ok = 0;
      end else begin
        chk(drv_a == eA, "R2 leg A per cycle", drv_a, eA);
        chk(drv_b == eB, "R3 leg B per cycle", drv_b, eB);
        chk(valley_stb == eS, "R1 period strobe", valley_stb, eS);
        if (r4_mode) chk(drv_a == drv_b, "R4 legs in phase", drv_a, drv_b);
        if (valley_stb) begin
          if (per_ok) begin
            chk(cyc == 2 * pP, "R1 period length", cyc, 2 * pP);
            chk(cA == 2 * pL, "R2 leg A duty", cA, 2 * pL);
            chk(cB == 2 * (pP - pL), "R3 leg B duty", cB, 2 * (pP - pL));
            lastA = cA; lastB = cB;
          end
          per_ok = 1; pL = m_L; pP = m_P; cA = 0; cB = 0; cyc = 0;
        end
        cA += drv_a; cB += drv_b; cyc++;
      end
    end
  end

  task automatic run(input int p, input int d, input int n);
    @(negedge clk);
    period = CW'(p);
    demand = (CW+1)'(d);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!drv_a && !drv_b && !valley_stb, "R8 reset outputs", {drv_a, drv_b, valley_stb}, 0);
    rst_n = 1'b1;
    enable = 1'b1;

    // R4: balanced point
    r4_mode = 1;
    run(16, 0, 100);
    chk(lastA == 16 && lastB == 16, "R4 half duty both legs", lastA, 16);
    r4_mode = 0;

    // R5: saturation both ways
    run(16, 40, 100);
    chk(lastA == 32 && lastB == 0, "R5 full A zero B", lastA, 32);
    run(16, -100, 100);
    chk(lastA == 0 && lastB == 32, "R5 zero A full B", lastA, 0);
    run(16, 8, 100);
    chk(lastA == 32, "R5 exact upper limit", lastA, 32);

    // R1: small span clamps to 2, odd span
    run(1, 0, 40);
    chk(lastA + lastB == 4, "R1 span below 2", lastA + lastB, 4);
    run(15, 3, 100);
    chk(lastA == 2 * 10, "R2 odd span", lastA, 20);

    // R6: mid-period demand/period change is deferred
    run(20, 5, 45);
    run(20, -5, 3);
    run(30, 2, 120);

    // R7: disable pulse and restart
    @(negedge clk); enable = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;
    chk(drv_a == eA, "R7 restart leg A", drv_a, eA);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int p = $urandom_range(40, 0);
      int d = int'($urandom_range(60, 0)) - 30;
      if ($urandom_range(9, 0) == 0) begin
        @(negedge clk); enable = 1'b0;
        repeat ($urandom_range(4, 1)) @(negedge clk);
        enable = 1'b1;
      end
      run(p, d, $urandom_range(200, 10));
    end

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule